// File: doc/BRIEF.md
# Dual-Channel Host Mailbox Registers

This block is a two-channel byte mailbox between an external host I/O bus and a local slave processor. In each channel the host deposits bytes into an input register. The slave deposits bytes into an output register, and the host collects them from there. Host accesses carry a 16-bit I/O address. One address bit picks the channel. On writes, a second address bit is kept as a marker that tells the slave whether the byte is a command or plain data.

Host reads are combinational. They return the selected output register, and they raise a decode-hit output when the address matches. Host writes land on the next rising clock edge. The slave side is a small register port with a 3-bit address. Slave reads are combinational. Slave writes reach only the two output registers.

Top module: `host_mailbox_regs`

## Requirements
- R1: A host access is decoded only when address bits 15..4 equal 0x006 and bits 3 and 0 are both 0. `host_hit` is high in the same cycle as a decoded write or decoded read.
- R2: On a decoded host write, address bit 1 picks the channel (0 = channel 1, 1 = channel 2). The write data is stored in that channel's input register and can be read on the slave port from the next cycle on.
- R3: On a decoded host write, address bit 2 is stored in the chosen channel's command flag (0 = data, 1 = command). Both flags read 0 after the synchronous active-high reset.
- R4: A host write leaves the other channel's input register and flag unchanged.
- R5: A host read is decoded only when address bit 2 is 0. Address 0x0060 returns channel 1's output register and 0x0062 returns channel 2's, in the same cycle, with `host_hit` high.
- R6: A host access that does not decode (for example 0x0061, 0x0068, 0x0160, or a read at 0x0064) changes nothing. During such an access `host_rdata` is 0x00 and `host_hit` is low.
- R7: A slave write to slave address 2 (channel 1) or 3 (channel 2) loads that output register on the next edge. The output register holds its value when it is not written.
- R8: Slave writes to slave addresses 0, 1 and 4 (input registers and flags) have no effect.
- R9: When a host write and a slave write happen in the same cycle, both take effect.
- R10: Slave read map: 0 = channel 1 input, 1 = channel 2 input, 2 = channel 1 output, 3 = channel 2 output, 4 = flags (bit 0 = channel 1, bit 1 = channel 2, other bits 0). All other slave addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all registers |
| rst | input | 1 | Synchronous active-high reset (flags only) |
| host_wr | input | 1 | Host I/O write strobe, one cycle per access |
| host_rd | input | 1 | Host I/O read strobe |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, 0x00 when not decoded |
| host_hit | output | 1 | High when the current host access decodes |
| slv_addr | input | 3 | Slave register address |
| slv_wr | input | 1 | Slave write strobe |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data (combinational) |

## Verification
Three outputs are combinational: `host_hit`, `host_rdata` and `slv_rdata`. They are sampled 1 ns after inputs change at a falling edge, inside the same cycle. Register updates from host or slave writes happen on the next rising edge. Each write strobe is therefore held for exactly one falling-to-falling interval, and its effect is read back on the slave port after the following falling edge, one cycle after the stimulus. Checks for "no effect" read back every register that the access could have touched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int NUM_CH    = 2;
    localparam int SLV_AW    = 3;
    localparam int BASE_W    = ADDR_W - 4;
    localparam logic [BASE_W-1:0] HOST_BASE = BASE_W'(12'h006);

    // Host address bit roles
    localparam int CH_BIT    = 1;
    localparam int CMD_BIT   = 2;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [SLV_AW-1:0] {
        SLV_IN_CH1  = 3'd0,
        SLV_IN_CH2  = 3'd1,
        SLV_OUT_CH1 = 3'd2,
        SLV_OUT_CH2 = 3'd3,
        SLV_FLAGS   = 3'd4
    } slv_reg_e;

    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
        logic ch;
        logic cmd;
    } host_dec_t;

    function automatic logic port_window(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:4] == HOST_BASE) && !a[3] && !a[0];
    endfunction

endpackage

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    output host_dec_t         dec,
    output logic [NUM_CH-1:0] wr_sel
);

    logic in_window;

    always_comb begin
        in_window  = port_window(host_addr);
        dec.ch     = host_addr[CH_BIT];
        dec.cmd    = host_addr[CMD_BIT];
        dec.wr_hit = host_wr && in_window;
        dec.rd_hit = host_rd && in_window && !host_addr[CMD_BIT];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign wr_sel[c] = dec.wr_hit && (dec.ch == 1'(c));
    end

    assert_wr_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

    assert_rd_data_port_R5: assert property (@(posedge clk) disable iff (rst)
        dec.rd_hit |-> (host_addr[CMD_BIT] == 1'b0 && host_rd));

endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_we,
    input  logic  host_cmd,
    input  byte_t host_wdata,
    input  logic  out_we,
    input  byte_t out_wdata,
    output byte_t in_q,
    output logic  flag_q,
    output byte_t out_q
);

    // Data registers carry no reset; their content is undefined until written.
    always_ff @(posedge clk) begin
        if (host_we) in_q <= host_wdata;
        if (out_we)  out_q <= out_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (host_we) flag_q <= host_cmd;
    end

    assert_in_capture_R2: assert property (@(posedge clk) disable iff (rst)
        host_we |=> in_q == $past(host_wdata));

    assert_flag_capture_R3: assert property (@(posedge clk) disable iff (rst)
        host_we |=> flag_q == $past(host_cmd));

    assert_in_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !host_we |=> ($stable(in_q) && $stable(flag_q)));

    assert_out_load_R7: assert property (@(posedge clk) disable iff (rst)
        out_we |=> out_q == $past(out_wdata));

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !out_we |=> $stable(out_q));

endmodule

// File: rtl/mbx_slave_port.sv
module mbx_slave_port
    import mbx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SLV_AW-1:0]             slv_addr,
    input  logic                          slv_wr,
    input  byte_t                         slv_wdata,
    input  logic [NUM_CH-1:0][DATA_W-1:0] in_q,
    input  logic [NUM_CH-1:0]             flag_q,
    input  logic [NUM_CH-1:0][DATA_W-1:0] out_q,
    output logic [NUM_CH-1:0]             out_we,
    output byte_t                         out_wdata,
    output byte_t                         slv_rdata
);

    slv_reg_e sel;

    assign sel       = slv_reg_e'(slv_addr);
    assign out_wdata = slv_wdata;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign out_we[c] = slv_wr && (slv_addr == SLV_AW'(SLV_OUT_CH1) + SLV_AW'(c));
    end

    always_comb begin
        case (sel)
            SLV_IN_CH1:  slv_rdata = in_q[0];
            SLV_IN_CH2:  slv_rdata = in_q[1];
            SLV_OUT_CH1: slv_rdata = out_q[0];
            SLV_OUT_CH2: slv_rdata = out_q[1];
            SLV_FLAGS:   slv_rdata = DATA_W'(flag_q);
            default:     slv_rdata = '0;
        endcase
    end

    assert_ro_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (slv_wr && slv_addr != SLV_AW'(SLV_OUT_CH1) && slv_addr != SLV_AW'(SLV_OUT_CH2))
            |-> out_we == '0);

endmodule

// File: rtl/host_mailbox_regs.sv
module host_mailbox_regs
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_hit,
    input  logic [SLV_AW-1:0] slv_addr,
    input  logic              slv_wr,
    input  logic [DATA_W-1:0] slv_wdata,
    output logic [DATA_W-1:0] slv_rdata
);

    host_dec_t                     dec;
    logic [NUM_CH-1:0]             wr_sel;
    logic [NUM_CH-1:0]             out_we;
    byte_t                         out_wdata;
    logic [NUM_CH-1:0][DATA_W-1:0] in_q;
    logic [NUM_CH-1:0][DATA_W-1:0] out_q;
    logic [NUM_CH-1:0]             flag_q;

    mbx_host_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .dec       (dec),
        .wr_sel    (wr_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        mbx_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .host_we    (wr_sel[c]),
            .host_cmd   (dec.cmd),
            .host_wdata (host_wdata),
            .out_we     (out_we[c]),
            .out_wdata  (out_wdata),
            .in_q       (in_q[c]),
            .flag_q     (flag_q[c]),
            .out_q      (out_q[c])
        );
    end

    mbx_slave_port u_slv (
        .clk       (clk),
        .rst       (rst),
        .slv_addr  (slv_addr),
        .slv_wr    (slv_wr),
        .slv_wdata (slv_wdata),
        .in_q      (in_q),
        .flag_q    (flag_q),
        .out_q     (out_q),
        .out_we    (out_we),
        .out_wdata (out_wdata),
        .slv_rdata (slv_rdata)
    );

    assign host_hit   = dec.wr_hit || dec.rd_hit;
    assign host_rdata = dec.rd_hit ? out_q[dec.ch] : '0;

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !host_hit |-> host_rdata == '0);

    assert_miss_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        !host_hit |=> ($stable(in_q) && $stable(flag_q)));

endmodule

// File: tb/tb_host_mailbox_regs.sv
`timescale 1ns/1ps
module tb_host_mailbox_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_hit;
    logic [2:0]  slv_addr = '0;
    logic        slv_wr = 1'b0;
    logic [7:0]  slv_wdata = '0;
    logic [7:0]  slv_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    host_mailbox_regs dut (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_hit(host_hit),
        .slv_addr(slv_addr), .slv_wr(slv_wr), .slv_wdata(slv_wdata),
        .slv_rdata(slv_rdata)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        hit;
        logic [7:0]  in1;
        logic [7:0]  in2;
        logic [1:0]  flags;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{16'h0064, 8'h33, 1'b1, 8'h33, 8'h22, 2'b01},  // R3 cmd ch1, R4
        '{16'h0066, 8'h44, 1'b1, 8'h33, 8'h44, 2'b11},  // R3 cmd ch2
        '{16'h0060, 8'h55, 1'b1, 8'h55, 8'h44, 2'b10},  // R3 data clears
        '{16'h0061, 8'h99, 1'b0, 8'h55, 8'h44, 2'b10},  // R6 bit0 set
        '{16'h0068, 8'h99, 1'b0, 8'h55, 8'h44, 2'b10},  // R6 bit3 set
        '{16'h0160, 8'h99, 1'b0, 8'h55, 8'h44, 2'b10},  // R1 upper bits
        '{16'h8062, 8'h99, 1'b0, 8'h55, 8'h44, 2'b10},  // R1 top bit
        '{16'h0062, 8'h66, 1'b1, 8'h55, 8'h66, 2'b00},  // R2 ch2
        '{16'h0070, 8'h99, 1'b0, 8'h55, 8'h66, 2'b00},  // R1 bit4
        '{16'h0066, 8'h77, 1'b1, 8'h55, 8'h77, 2'b10},  // R4 ch1 kept
        '{16'h0064, 8'h88, 1'b1, 8'h88, 8'h77, 2'b11},  // R4 ch2 kept
        '{16'h0063, 8'h99, 1'b0, 8'h88, 8'h77, 2'b11}   // R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d, output logic hit);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        #1 hit = host_hit;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [15:0] a, output logic [7:0] d, output logic hit);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 begin d = host_rdata; hit = host_hit; end
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic slave_read(input logic [2:0] a, output logic [7:0] d);
        slv_addr = a;
        #1 d = slv_rdata;
    endtask

    task automatic slave_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        slv_addr = a; slv_wdata = d; slv_wr = 1'b1;
        @(negedge clk);
        slv_wr = 1'b0;
    endtask

    task automatic check_state(input string req, input logic [7:0] e1,
                               input logic [7:0] e2, input logic [1:0] ef);
        logic [7:0] r;
        slave_read(3'd0, r); check(req, r, e1);
        slave_read(3'd1, r); check(req, r, e2);
        slave_read(3'd4, r); check(req, r, {6'b0, ef});
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic       h;
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state: flags clear, idle outputs quiet
        slave_read(3'd4, r); check("R3 reset flags", r, 8'h00);
        #1 check("R6 idle hit", {7'b0, host_hit}, 8'h00);
        check("R6 idle rdata", host_rdata, 8'h00);

        // Define both input registers
        host_write(16'h0060, 8'h11, h); check("R2 hit ch1", {7'b0, h}, 8'h01);
        host_write(16'h0062, 8'h22, h); check("R2 hit ch2", {7'b0, h}, 8'h01);
        check_state("R2 initial fill", 8'h11, 8'h22, 2'b00);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            host_write(VECS[i].addr, VECS[i].data, h);
            check($sformatf("R1 hit vec %0d", i), {7'b0, h}, {7'b0, VECS[i].hit});
            check_state($sformatf("R2/R3/R4/R6 vec %0d", i),
                        VECS[i].in1, VECS[i].in2, VECS[i].flags);
        end

        // Slave output registers
        slave_write(3'd2, 8'hC3);
        slave_write(3'd3, 8'h3C);
        slave_read(3'd2, r); check("R7 out ch1", r, 8'hC3);
        slave_read(3'd3, r); check("R7 out ch2", r, 8'h3C);
        slave_read(3'd5, r); check("R10 unmapped 5", r, 8'h00);
        slave_read(3'd7, r); check("R10 unmapped 7", r, 8'h00);

        // Host reads
        host_read(16'h0060, r, h); check("R5 read ch1", r, 8'hC3);
        check("R5 hit ch1", {7'b0, h}, 8'h01);
        host_read(16'h0062, r, h); check("R5 read ch2", r, 8'h3C);
        check("R5 hit ch2", {7'b0, h}, 8'h01);
        host_read(16'h0064, r, h); check("R6 read 0x64 data", r, 8'h00);
        check("R6 read 0x64 hit", {7'b0, h}, 8'h00);
        host_read(16'h0066, r, h); check("R6 read 0x66 data", r, 8'h00);
        host_read(16'h0061, r, h); check("R6 read 0x61 data", r, 8'h00);
        check("R6 read 0x61 hit", {7'b0, h}, 8'h00);
        host_read(16'h0160, r, h); check("R6 read 0x160 hit", {7'b0, h}, 8'h00);

        // Slave writes to read-only registers
        slave_write(3'd0, 8'hEE);
        slave_write(3'd1, 8'hEE);
        slave_write(3'd4, 8'hFF);
        check_state("R8 ro ignored", 8'h88, 8'h77, 2'b11);
        slave_read(3'd2, r); check("R8 out1 kept", r, 8'hC3);
        slave_read(3'd3, r); check("R8 out2 kept", r, 8'h3C);

        // Simultaneous host and slave writes
        @(negedge clk);
        host_addr = 16'h0060; host_wdata = 8'h5A; host_wr = 1'b1;
        slv_addr = 3'd3; slv_wdata = 8'hA5; slv_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; slv_wr = 1'b0;
        check_state("R9 host side", 8'h5A, 8'h77, 2'b10);
        slave_read(3'd3, r); check("R9 slave side", r, 8'hA5);
        slave_read(3'd2, r); check("R9 out1 kept", r, 8'hC3);

        // Reset again: flags clear
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        slave_read(3'd4, r); check("R3 flags after reset", r, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule